// File: doc/BRIEF.md
# Shared Message-RAM Slot Arbiter

This block lets one host CPU port and up to four CAN controller nodes share a single-port message RAM. Each clock cycle is one access slot. In every slot the block picks one requester, drives the RAM address, write data and write enable from that requester, and raises its bit in a one-hot grant vector. A requester that is not marked active is never picked, so the RAM bandwidth is split only among the parties that need it.

While the CPU is active and at least one CAN node is active, the CPU owns every other slot. The remaining slots rotate among the active CAN nodes in ascending index order. An inactive node is skipped and leaves no empty slot behind. When the CPU is idle, the CAN nodes share all the slots. Read data comes back from the RAM one cycle after the read slot. The block forwards it to the requester that issued the read, together with a one-hot valid strobe.

Top module: `can_ram_slot_arb`

## Requirements
- R1: `grant` is one-hot whenever any bit of `req_active` is set, and it is all-zero (with `ram_en` low) when no requester is active.
- R2: A requester whose `req_active` bit is low is never granted. Bit 0 is the CPU and bit k (1..4) is CAN node k-1. With only the CPU active, every slot goes to the CPU.
- R3: While the CPU and at least one CAN node stay active, CPU slots and CAN slots alternate, so the CPU holds every second slot.
- R4: With the CPU and three CAN nodes active, each of those nodes is granted once every six slots.
- R5: With the CPU inactive and all four CAN nodes active, each node is granted once every four slots.
- R6: With the CPU and two CAN nodes active, each of those nodes is granted once every four slots.
- R7: With the CPU inactive and two CAN nodes active, each of those nodes is granted once every two slots.
- R8: CAN slots go to active nodes in ascending index order. The order wraps from the highest active node to the lowest, and inactive nodes are skipped.
- R9: After synchronous active-low reset, the first granted slot goes to the CPU if the CPU is active, and otherwise to the lowest-indexed active CAN node.
- R10: In each granted slot, `ram_en` is high, and `ram_addr`, `ram_wdata` and `ram_we` equal the granted requester's address, data and write-enable fields.
- R11: One cycle after a read slot (a slot with `ram_we` low), `rsp_valid` holds exactly the bit of the requester that was granted, and `rsp_rdata` equals `ram_rdata`. After a write slot or an empty slot, `rsp_valid` is zero.
- R12: A change of `req_active` takes effect in the slot where it appears. The rotation continues from the last CAN node served and does not restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| req_active | input | N_CAN+1 | Activity flag per requester (bit 0 CPU) |
| req_addr | input | (N_CAN+1)*AW | Packed address per requester, requester i at bits i*AW |
| req_wdata | input | (N_CAN+1)*DW | Packed write data per requester |
| req_we | input | N_CAN+1 | Write enable per requester |
| ram_rdata | input | DW | Read data from RAM, one cycle after the read slot |
| grant | output | N_CAN+1 | One-hot slot owner |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| rsp_valid | output | N_CAN+1 | One-hot read-response strobe |
| rsp_rdata | output | DW | Read data forwarded to the requester |

## Verification
The arbiter is driven with the four sharing mixes: CPU with three nodes, CPU idle with four nodes, CPU with two non-adjacent nodes, and CPU idle with two nodes. These show whether the CPU interleave and the per-node slot periods come out right. The mixes with gaps among the active nodes show whether inactive nodes are skipped rather than left holding empty slots. A run that changes activity in the middle shows whether the rotation resumes from the last node served, and whether a newly active CPU takes the very next slot. Idle and CPU-only patterns cover the zero grant. A write enable for the CPU combined with reads for the nodes shows whether responses are steered to the reader and suppressed after writes.

// File: rtl/can_slot_pkg.sv
package can_slot_pkg;
   // Which side owns the next slot when both sides have demand
   typedef enum logic {
      PH_CPU = 1'b0,
      PH_CAN = 1'b1
   } slot_phase_e;
endpackage

// File: rtl/slot_sched.sv
module slot_sched
   import can_slot_pkg::*;
#(
   parameter int N_CAN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_act,
   input  logic [N_CAN-1:0] can_act,
   output logic             grant_cpu,
   output logic [N_CAN-1:0] grant_can
);
   localparam int PW = (N_CAN > 1) ? $clog2(N_CAN) : 1;

   slot_phase_e   phase_q;
   logic [PW-1:0] last_q;
   logic [PW-1:0] pick;
   logic          found;
   logic          can_any;
   logic          cpu_win;

   // Search the CAN nodes cyclically, starting after the last one served
   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int k = 1; k <= N_CAN; k++) begin
         int c;
         c = (int'(last_q) + k) % N_CAN;
         if (!found && can_act[c]) begin
            found = 1'b1;
            pick  = PW'(c);
         end
      end
   end

   assign can_any   = |can_act;
   assign cpu_win   = cpu_act && ((phase_q == PH_CPU) || !can_any);
   assign grant_cpu = cpu_win;

   for (genvar i = 0; i < N_CAN; i++) begin : g_gnt
      assign grant_can[i] = !cpu_win && found && (pick == PW'(i));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_CPU;
         last_q  <= PW'(N_CAN - 1);
      end else if (cpu_win) begin
         phase_q <= PH_CAN;
      end else if (found) begin
         phase_q <= PH_CPU;
         last_q  <= pick;
      end
   end
endmodule

// File: rtl/slot_mux.sv
module slot_mux #(
   parameter int N_REQ      = 5,
   parameter int AW         = 10,
   parameter int DW         = 32,
   parameter bit ONEHOT_MUX = 1'b1
) (
   input  logic [N_REQ-1:0]    grant,
   input  logic [N_REQ*AW-1:0] addr_flat,
   input  logic [N_REQ*DW-1:0] wdata_flat,
   input  logic [N_REQ-1:0]    we_vec,
   output logic                ram_en,
   output logic                ram_we,
   output logic [AW-1:0]       ram_addr,
   output logic [DW-1:0]       ram_wdata
);
   localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1;

   assign ram_en = |grant;

   if (ONEHOT_MUX) begin : g_andor
      // AND-OR reduction: shallow, relies on grant being one-hot
      always_comb begin
         ram_addr  = '0;
         ram_wdata = '0;
         ram_we    = 1'b0;
         for (int i = 0; i < N_REQ; i++) begin
            ram_addr  = ram_addr  | (addr_flat[i*AW +: AW]  & {AW{grant[i]}});
            ram_wdata = ram_wdata | (wdata_flat[i*DW +: DW] & {DW{grant[i]}});
            ram_we    = ram_we    | (we_vec[i] & grant[i]);
         end
      end
   end else begin : g_encoded
      // Encode the grant, then index the buses
      logic [IW-1:0] sel;
      always_comb begin
         sel = '0;
         for (int i = 0; i < N_REQ; i++) begin
            if (grant[i]) sel = IW'(i);
         end
      end
      assign ram_addr  = addr_flat[int'(sel)*AW +: AW];
      assign ram_wdata = wdata_flat[int'(sel)*DW +: DW];
      assign ram_we    = ram_en & we_vec[sel];
   end
endmodule

// File: rtl/slot_rsp.sv
module slot_rsp #(
   parameter int N_REQ = 5,
   parameter int DW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] grant,
   input  logic             ram_we,
   input  logic [DW-1:0]    ram_rdata,
   output logic [N_REQ-1:0] rsp_valid,
   output logic [DW-1:0]    rsp_rdata
);
   logic [N_REQ-1:0] rd_owner_q;

   always_ff @(posedge clk) begin
      if (!rst_n) rd_owner_q <= '0;
      else        rd_owner_q <= ram_we ? '0 : grant;
   end

   assign rsp_valid = rd_owner_q;
   assign rsp_rdata = ram_rdata;
endmodule

// File: rtl/can_ram_slot_arb.sv
module can_ram_slot_arb #(
   parameter int N_CAN      = 4,
   parameter int AW         = 10,
   parameter int DW         = 32,
   parameter bit ONEHOT_MUX = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_CAN:0]            req_active,
   input  logic [(N_CAN+1)*AW-1:0]   req_addr,
   input  logic [(N_CAN+1)*DW-1:0]   req_wdata,
   input  logic [N_CAN:0]            req_we,
   input  logic [DW-1:0]             ram_rdata,
   output logic [N_CAN:0]            grant,
   output logic                      ram_en,
   output logic                      ram_we,
   output logic [AW-1:0]             ram_addr,
   output logic [DW-1:0]             ram_wdata,
   output logic [N_CAN:0]            rsp_valid,
   output logic [DW-1:0]             rsp_rdata
);
   localparam int N_REQ = N_CAN + 1;

   if (N_CAN < 1 || N_CAN > 16) begin : g_bad_ncan
      $error("can_ram_slot_arb: N_CAN must be 1..16");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("can_ram_slot_arb: AW and DW must be positive");
   end

   logic             gnt_cpu;
   logic [N_CAN-1:0] gnt_can;

   slot_sched #(.N_CAN(N_CAN)) u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_act   (req_active[0]),
      .can_act   (req_active[N_CAN:1]),
      .grant_cpu (gnt_cpu),
      .grant_can (gnt_can)
   );

   assign grant = {gnt_can, gnt_cpu};

   slot_mux #(.N_REQ(N_REQ), .AW(AW), .DW(DW), .ONEHOT_MUX(ONEHOT_MUX)) u_mux (
      .grant      (grant),
      .addr_flat  (req_addr),
      .wdata_flat (req_wdata),
      .we_vec     (req_we),
      .ram_en     (ram_en),
      .ram_we     (ram_we),
      .ram_addr   (ram_addr),
      .ram_wdata  (ram_wdata)
   );

   slot_rsp #(.N_REQ(N_REQ), .DW(DW)) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant     (grant),
      .ram_we    (ram_we),
      .ram_rdata (ram_rdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );
endmodule

// File: rtl/can_ram_slot_arb_chk.sv
module can_ram_slot_arb_chk #(
   parameter int N_CAN = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic [N_CAN:0] req_active,
   input logic [N_CAN:0] grant,
   input logic           ram_en,
   input logic           ram_we,
   input logic [N_CAN:0] rsp_valid
);
   assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_busy_granted_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_active != '0) |-> (grant != '0));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_active == '0) |-> (!ram_en));

   assert_only_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req_active) == '0);

   assert_cpu_yields_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[0] && (|req_active[N_CAN:1])) |=> (!grant[0] || !(|req_active[N_CAN:1])));

   assert_cpu_returns_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant != '0) && !grant[0]) |=> (!req_active[0] || grant[0]));

   assert_enable_on_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0) |-> ram_en);

   assert_read_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en && !ram_we) |=> (rsp_valid == $past(grant)));

   assert_write_no_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_en || ram_we) |=> (rsp_valid == '0));
endmodule

bind can_ram_slot_arb can_ram_slot_arb_chk #(.N_CAN(N_CAN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_active (req_active),
   .grant      (grant),
   .ram_en     (ram_en),
   .ram_we     (ram_we),
   .rsp_valid  (rsp_valid)
);

// File: tb/can_ram_slot_arb_bench.sv
module can_ram_slot_arb_bench;
   localparam int N_CAN = 4;
   localparam int N_REQ = N_CAN + 1;
   localparam int AW    = 10;
   localparam int DW    = 32;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [N_REQ-1:0]    req_active = '0;
   logic [N_REQ*AW-1:0] req_addr;
   logic [N_REQ*DW-1:0] req_wdata;
   logic [N_REQ-1:0]    req_we = '0;
   logic [DW-1:0]       ram_rdata = '0;
   logic [N_REQ-1:0]    grant;
   logic                ram_en, ram_we;
   logic [AW-1:0]       ram_addr;
   logic [DW-1:0]       ram_wdata;
   logic [N_REQ-1:0]    rsp_valid;
   logic [DW-1:0]       rsp_rdata;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   int  cyc = 0;

   // Scoreboard queues, one entry per checked slot
   logic [N_REQ-1:0] q_grant[$];
   logic [AW-1:0]    q_addr[$];
   logic [DW-1:0]    q_wdata[$];
   logic             q_we[$];
   logic [N_REQ-1:0] q_rsp[$];
   string            q_tag[$];
   logic [N_REQ-1:0] prev_rd = '0;

   always #10 clk = ~clk;

   can_ram_slot_arb #(.N_CAN(N_CAN), .AW(AW), .DW(DW)) u_can_ram_slot_arb (
      .clk(clk), .rst_n(rst_n), .req_active(req_active), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_we(req_we), .ram_rdata(ram_rdata),
      .grant(grant), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   initial begin
      for (int i = 0; i < N_REQ; i++) begin
         req_addr[i*AW +: AW]  = AW'(i*64 + 7);
         req_wdata[i*DW +: DW] = 32'hD000_0000 + DW'(i);
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   // Driver: applies one slot of stimulus and pushes what must come out
   task automatic drive_cycle(input logic [N_REQ-1:0] act, input logic [N_REQ-1:0] we,
                              input int idx, input string tag);
      @(negedge clk);
      cyc++;
      req_active = act;
      req_we     = we;
      ram_rdata  = 32'hC0DE_0000 + DW'(cyc);
      q_grant.push_back(idx < 0 ? '0 : N_REQ'(1) << idx);
      q_addr.push_back(idx < 0 ? '0 : AW'(idx*64 + 7));
      q_wdata.push_back(idx < 0 ? '0 : 32'hD000_0000 + DW'(idx));
      q_we.push_back(idx < 0 ? 1'b0 : we[idx]);
      q_rsp.push_back(prev_rd);
      q_tag.push_back(tag);
      prev_rd = (idx >= 0 && !we[idx]) ? (N_REQ'(1) << idx) : '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      req_active = '0;
      req_we = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      prev_rd = '0;
   endtask

   // Expected sequence after reset, built from the sharing rule
   task automatic run_pattern(input bit cpu, input logic [N_CAN-1:0] canm,
                              input logic [N_REQ-1:0] we, input int n, input string tag);
      int lst[$];
      for (int j = 0; j < N_CAN; j++) if (canm[j]) lst.push_back(j + 1);
      for (int k = 0; k < n; k++) begin
         int idx;
         if (cpu && lst.size() > 0) idx = (k % 2 == 0) ? 0 : lst[(k/2) % lst.size()];
         else if (cpu)              idx = 0;
         else if (lst.size() > 0)   idx = lst[k % lst.size()];
         else                       idx = -1;
         drive_cycle({canm, cpu}, we, idx, tag);
      end
   endtask

   // Monitor: pops and compares away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (q_grant.size() > 0) begin
            logic [N_REQ-1:0] eg, er;
            string t;
            eg = q_grant.pop_front();
            er = q_rsp.pop_front();
            t  = q_tag.pop_front();
            check(grant == eg, t, "grant", DW'(grant), DW'(eg));
            check(ram_en == (eg != '0), "R10", "ram_en", DW'(ram_en), DW'(eg != '0));
            if (eg != '0) begin
               check(ram_addr == q_addr[0] && ram_wdata == q_wdata[0] && ram_we == q_we[0],
                     "R10", "ram port addr", DW'(ram_addr), DW'(q_addr[0]));
            end
            void'(q_addr.pop_front());
            void'(q_wdata.pop_front());
            void'(q_we.pop_front());
            check(rsp_valid == er, "R11", "rsp_valid", DW'(rsp_valid), DW'(er));
            if (er != '0)
               check(rsp_rdata == ram_rdata, "R11", "rsp_rdata", rsp_rdata, ram_rdata);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: nothing active -> zero grant, no RAM access
      drive_cycle('0, '0, -1, "R1");
      drive_cycle('0, '0, -1, "R1");
      // R2: CPU alone takes every slot, no node granted
      run_pattern(1'b1, 4'b0000, '0, 4, "R2");

      // R4 R3 R9: CPU + nodes 0,1,2; CPU writes, nodes read
      do_reset();
      run_pattern(1'b1, 4'b0111, 5'b00001, 18, "R4 R3 R9");

      // R5 R9: CPU idle, all four nodes
      do_reset();
      run_pattern(1'b0, 4'b1111, '0, 12, "R5 R9");

      // R6 R8: CPU + nodes 1 and 3 (gap skipped)
      do_reset();
      run_pattern(1'b1, 4'b1010, 5'b00100, 12, "R6 R8");

      // R7 R8: CPU idle, nodes 0 and 2
      do_reset();
      run_pattern(1'b0, 4'b0101, 5'b10100, 8, "R7 R8");

      // R12: activity changes mid-run, rotation continues
      do_reset();
      drive_cycle(5'b11110, '0, 1, "R12");
      drive_cycle(5'b11110, '0, 2, "R12");
      drive_cycle(5'b10010, '0, 4, "R12");
      drive_cycle(5'b10010, '0, 1, "R12");
      drive_cycle(5'b10010, '0, 4, "R12");
      drive_cycle(5'b10011, '0, 0, "R12 R3");
      drive_cycle(5'b10011, '0, 1, "R12 R3");
      drive_cycle(5'b10011, '0, 0, "R12 R3");
      drive_cycle(5'b10011, '0, 4, "R12 R8");
      drive_cycle(5'b00000, '0, -1, "R12 R1");
      drive_cycle(5'b00000, '0, -1, "R1");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule